// File: doc/BRIEF.md
# Public-Key Accelerator Control Front End

This block is the register and operand-memory front end that sits between a host bus and a public-key arithmetic engine. The host writes operands into a window of 64-bit words, chooses an operation through a mode field, enables the unit, waits for it to report that initialisation is done, and then starts the operation. Completion, illegal accesses, memory access during a run and rejected modes are all reported as sticky flags. Each flag can raise the interrupt line, and each is acknowledged by writing a one to the same bit position of the clear register.

The arithmetic engine is represented by a stub. It stays busy for a number of cycles set by a parameter for each mode. In signature-verification mode it writes the "valid" result code into the result word. Dropping the enable bit aborts any run, clears init-ready and makes the whole operand memory read as zero. The version and identification words are read-only constants.

Byte addresses are 13 bits wide. A request is a single-cycle `req_valid` pulse. Read data comes back one clock later with `rsp_valid`, and register reads use the low 32 bits.

Top module: `pka_ctrl_front`

## Requirements
- R1: After reset, the control register and the status register both read 0, `irq` is 0 and the operand memory reads as zero.
- R2: Offset 0x1FF4 reads the revision word, with the major revision in bits 7:4 and the minor revision in bits 3:0. Offset 0x1FF8 reads `ID_VALUE`. Writes to either offset have no effect.
- R3: Status bit 0 (init-ready) rises `INIT_CYCLES` clocks after the edge that sets control bit 0 (enable). It clears on the edge where enable is written 0.
- R4: A control write with bit 1 (start) and bit 0 set launches a run only if enable and init-ready are both already 1, status bit 16 (busy) is 0, and bits 13:8 hold 0x09 (addition) or 0x26 (verification). When it launches, busy stays high for `ADD_CYCLES` or `VERIFY_CYCLES` clocks. The start bit always reads back 0.
- R5: When a run completes, status bit 17 (run-done) sets. A verification run writes 0xD60D into the word at offset 0x5D0. An addition run leaves the memory unchanged.
- R6: An accepted start whose mode code is neither 0x09 nor 0x26 sets status bit 21 (mode error) and does not raise busy.
- R7: Any access that decodes to neither a register nor an 8-byte-aligned word inside the memory window sets status bit 20 (address error).
- R8: Any memory access while busy sets status bit 19 (memory-conflict error). Such a write is dropped and such a read returns 0.
- R9: Writing ones to bits 21, 20, 19 or 17 at offset 0x8 clears those flags and leaves the other flags unchanged. A flag being set in the same cycle wins over the clear. Offset 0x8 reads 0.
- R10: `irq` is high exactly when some flag bit is set and the control bit at the same position (21, 20, 19 or 17) is set.
- R11: Writing control bit 0 as 0 during a run ends busy on that edge without setting run-done. Afterwards every memory word, the result word included, reads 0.
- R12: The memory window starts at 0x400 and holds 5336 bytes (667 words, last word at 0x18D0). A word written while idle reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 64 | Write data (registers use bits 31:0) |
| rsp_valid | output | 1 | Read data valid, one clock after a read request |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Interrupt: some enabled flag is set |

## Verification
The bench goes after the places where ordering matters. Writing start together with enable in the same write must be refused, because a design that looks at the incoming enable bit instead of the stored one would launch before init-ready is up. A second start issued while busy, carrying a bad mode, must neither restart the counter nor set the mode error; a design that got this wrong would shorten or stretch the run. Disabling mid-run must leave run-done clear and make the result word read zero, which catches a design that lets the engine finish or that only wipes the memory after a delay. The bench also probes the last legal word, the first byte beyond the window and a misaligned word address, to expose off-by-one decoding.

// File: rtl/pka_front_pkg.sv
package pka_front_pkg;

  localparam int ADDR_W     = 13;
  localparam int RAM_BASE   = 'h400;
  localparam int RAM_BYTES  = 5336;
  localparam int RAM_WORDS  = RAM_BYTES / 8;
  localparam int IDX_W      = $clog2(RAM_WORDS);
  localparam int RESULT_IDX = ('h5D0 - RAM_BASE) / 8;

  localparam logic [5:0]  MODE_ADD    = 6'h09;
  localparam logic [5:0]  MODE_VERIFY = 6'h26;
  localparam logic [63:0] CODE_VALID  = 64'hD60D;

  // Flag positions shared by interrupt enables, sticky flags and clear strobes
  localparam int F_MODE = 21;
  localparam int F_ADDR = 20;
  localparam int F_RAM  = 19;
  localparam int F_DONE = 17;
  localparam logic [31:0] FLAG_MASK = (32'd1 << F_MODE) | (32'd1 << F_ADDR) |
                                      (32'd1 << F_RAM)  | (32'd1 << F_DONE);

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_STAT, SEL_CLR, SEL_VER, SEL_ID, SEL_RAM, SEL_BAD
  } sel_e;

  function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
    sel_e s;
    if (a == 13'h000)       s = SEL_CTRL;
    else if (a == 13'h004)  s = SEL_STAT;
    else if (a == 13'h008)  s = SEL_CLR;
    else if (a == 13'h1FF4) s = SEL_VER;
    else if (a == 13'h1FF8) s = SEL_ID;
    else if (int'(a) >= RAM_BASE && int'(a) < RAM_BASE + RAM_BYTES && a[2:0] == 3'b000)
      s = SEL_RAM;
    else s = SEL_BAD;
    return s;
  endfunction

  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - ADDR_W'(RAM_BASE);
    return off[IDX_W+2:3];
  endfunction

  function automatic logic mode_known(input logic [5:0] m);
    return (m == MODE_ADD) || (m == MODE_VERIFY);
  endfunction

endpackage

// File: rtl/pka_init_seq.sv
module pka_init_seq #(
  parameter int INIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drop,
  output logic init_ok
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      init_ok <= 1'b0;
    end else if (!en || drop) begin
      cnt     <= '0;
      init_ok <= 1'b0;
    end else if (!init_ok) begin
      if (cnt == CW'(INIT_CYCLES - 1)) init_ok <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pka_engine_stub.sv
module pka_engine_stub #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] run_len,
  input  logic             abort,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == CNT_W'(1)) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      if (abort) busy <= 1'b0;
      else if (busy) begin
        if (cnt == CNT_W'(1)) busy <= 1'b0;
        else                  cnt  <= cnt - 1'b1;
      end
      if (launch) begin
        busy <= 1'b1;
        cnt  <= run_len;
      end
    end
  end
endmodule

// File: rtl/pka_opram.sv
module pka_opram #(
  parameter int WORDS = 667,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data
);
  logic [63:0]      mem [WORDS];
  logic [WORDS-1:0] live;

  // A word that has not been written since the last wipe reads as zero
  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < WORDS && live[rd_idx]) rd_data = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else if (wipe) live <= '0;
    else if (wr_en && int'(wr_idx) < WORDS) live[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wipe && int'(wr_idx) < WORDS) mem[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/pka_ctrl_front.sv
module pka_ctrl_front
  import pka_front_pkg::*;
#(
  parameter int          INIT_CYCLES   = 4,
  parameter int          ADD_CYCLES    = 6,
  parameter int          VERIFY_CYCLES = 20,
  parameter logic [3:0]  VER_MAJOR     = 4'd2,
  parameter logic [3:0]  VER_MINOR     = 4'd3,
  parameter logic [31:0] ID_VALUE      = 32'h0031_0017
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              irq
);
  localparam int RUN_MAX = (ADD_CYCLES > VERIFY_CYCLES) ? ADD_CYCLES : VERIFY_CYCLES;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);

  sel_e             sel;
  logic             en_q, init_ok, busy, eng_done;
  logic [5:0]       mode_q, run_mode_q;
  logic [31:0]      ie_q, flags_q, flag_set, flag_clr;
  logic             wr_ctrl, wr_clr, disable_wr, start_req, launch, mode_fault;
  logic             bad_access, ram_acc, ram_blocked;
  logic             ram_wr_en;
  logic [IDX_W-1:0] ram_wr_idx, host_idx;
  logic [63:0]      ram_wr_data, ram_rd_data, rd_word;
  logic [CNT_W-1:0] run_len;

  assign sel         = decode_addr(req_addr);
  assign host_idx    = word_index(req_addr);
  assign wr_ctrl     = req_valid && req_write && (sel == SEL_CTRL);
  assign wr_clr      = req_valid && req_write && (sel == SEL_CLR);
  assign disable_wr  = wr_ctrl && !req_wdata[0];
  assign bad_access  = req_valid && (sel == SEL_BAD);
  assign ram_acc     = req_valid && (sel == SEL_RAM);
  assign ram_blocked = ram_acc && busy;

  // Start is judged against the stored enable, not the incoming one
  assign start_req  = wr_ctrl && req_wdata[1] && req_wdata[0] && en_q && init_ok && !busy;
  assign launch     = start_req && mode_known(req_wdata[13:8]);
  assign mode_fault = start_req && !mode_known(req_wdata[13:8]);
  assign run_len    = (req_wdata[13:8] == MODE_VERIFY) ? CNT_W'(VERIFY_CYCLES)
                                                       : CNT_W'(ADD_CYCLES);

  always_comb begin
    flag_set         = '0;
    flag_set[F_MODE] = mode_fault;
    flag_set[F_ADDR] = bad_access;
    flag_set[F_RAM]  = ram_blocked;
    flag_set[F_DONE] = eng_done;
    flag_clr         = wr_clr ? (req_wdata[31:0] & FLAG_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      mode_q     <= '0;
      ie_q       <= '0;
      flags_q    <= '0;
      run_mode_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= req_wdata[0];
        mode_q <= req_wdata[13:8];
        ie_q   <= req_wdata[31:0] & FLAG_MASK;
      end
      if (launch) run_mode_q <= req_wdata[13:8];
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  pka_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .en(en_q), .drop(disable_wr), .init_ok(init_ok)
  );

  pka_engine_stub #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run_len(run_len),
    .abort(disable_wr), .busy(busy), .done(eng_done)
  );

  // Engine result and host writes never coincide: host writes are dropped while busy
  always_comb begin
    ram_wr_en   = ram_acc && req_write && !busy;
    ram_wr_idx  = host_idx;
    ram_wr_data = req_wdata;
    if (eng_done && run_mode_q == MODE_VERIFY) begin
      ram_wr_en   = 1'b1;
      ram_wr_idx  = IDX_W'(RESULT_IDX);
      ram_wr_data = CODE_VALID;
    end
  end

  pka_opram #(.WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wipe(disable_wr),
    .wr_en(ram_wr_en), .wr_idx(ram_wr_idx), .wr_data(ram_wr_data),
    .rd_idx(host_idx), .rd_data(ram_rd_data)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rd_word = {32'd0, ie_q | {18'd0, mode_q, 7'd0, en_q}};
      SEL_STAT: rd_word = {32'd0, flags_q | {15'd0, busy, 15'd0, init_ok}};
      SEL_VER:  rd_word = {56'd0, VER_MAJOR, VER_MINOR};
      SEL_ID:   rd_word = {32'd0, ID_VALUE};
      SEL_RAM:  rd_word = busy ? 64'd0 : ram_rd_data;
      default:  rd_word = 64'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : 64'd0;
    end
  end

  assign irq = |(flags_q & ie_q);

endmodule

// File: rtl/pka_ctrl_front_chk.sv
module pka_ctrl_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        init_ok,
  input logic        busy,
  input logic        launch,
  input logic        disable_wr,
  input logic        bad_access,
  input logic        wr_clr,
  input logic [31:0] flags_q,
  input logic        req_valid,
  input logic        req_write,
  input logic [63:0] req_wdata,
  input logic        rsp_valid
);
  p_init_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ok) |-> en_q);

  p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (flags_q[17] || !en_q));

  p_addr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> flags_q[20]);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[17]) |-> $past(wr_clr && req_wdata[17]));

  p_addr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[20]) |-> $past(wr_clr && req_wdata[20]));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disable_wr |=> (!busy && !init_ok && !en_q));

  p_rsp_follows_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind pka_ctrl_front pka_ctrl_front_chk u_chk (.*);

// File: tb/pka_ctrl_front_tb.sv
`timescale 1ns/1ps
module pka_ctrl_front_tb;
  localparam int INIT = 4, ADDC = 6, VERC = 20;
  localparam logic [31:0] MASK = 32'h003A_0000;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [12:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, irq;
  logic [63:0] rsp_rdata;

  int errors = 0, checks = 0, cyc = 0;
  string tag = "R1";

  pka_ctrl_front #(.INIT_CYCLES(INIT), .ADD_CYCLES(ADDC), .VERIFY_CYCLES(VERC),
    .VER_MAJOR(4'd2), .VER_MINOR(4'd3), .ID_VALUE(32'h0031_0017)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  // Behavioural reference model
  bit        m_en, m_init, m_busy, m_rv;
  int        m_icnt, m_bcnt;
  bit [5:0]  m_mode, m_run;
  bit [31:0] m_ie, m_flags;
  bit [63:0] m_rd;
  bit [63:0] m_ram [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_init = 0; m_busy = 0; m_rv = 0; m_icnt = 0; m_bcnt = 0;
      m_mode = 0; m_run = 0; m_ie = 0; m_flags = 0; m_rd = 0; m_ram.delete();
    end else begin
      int k, idx, a;
      bit v, w, wctrl, abort, start, known, done;
      bit [31:0] nf;
      a = int'(req_addr); v = req_valid; w = req_write;
      if (a == 0) k = 0; else if (a == 4) k = 1; else if (a == 8) k = 2;
      else if (a == 'h1FF4) k = 3; else if (a == 'h1FF8) k = 4;
      else if (a >= 1024 && a < 1024 + 5336 && a % 8 == 0) k = 5; else k = 6;
      idx = (a - 1024) / 8;
      m_rv = v && !w; m_rd = 0;
      if (m_rv) begin
        case (k)
          0: m_rd = {32'd0, m_ie | (32'(m_mode) << 8) | 32'(m_en)};
          1: m_rd = {32'd0, m_flags | (32'(m_busy) << 16) | 32'(m_init)};
          3: m_rd = 64'h23;
          4: m_rd = 64'h0031_0017;
          5: m_rd = (!m_busy && m_ram.exists(idx)) ? m_ram[idx] : 64'd0;
          default: m_rd = 0;
        endcase
      end
      wctrl = v && w && k == 0;
      abort = wctrl && !req_wdata[0];
      known = req_wdata[13:8] == 6'h09 || req_wdata[13:8] == 6'h26;
      start = wctrl && req_wdata[1] && req_wdata[0] && m_en && m_init && !m_busy;
      done  = m_busy && m_bcnt == 1 && !abort;
      nf = m_flags;
      if (v && w && k == 2) nf &= ~(req_wdata[31:0] & MASK);
      if (start && !known) nf[21] = 1;
      if (v && k == 6) nf[20] = 1;
      if (v && k == 5 && m_busy) nf[19] = 1;
      if (done) nf[17] = 1;
      if (v && w && k == 5 && !m_busy) m_ram[idx] = req_wdata;
      if (done && m_run == 6'h26) m_ram[58] = 64'hD60D;
      if (abort) m_ram.delete();
      if (!m_en || abort) begin m_icnt = 0; m_init = 0; end
      else if (!m_init) begin if (m_icnt == INIT - 1) m_init = 1; m_icnt++; end
      if (abort) m_busy = 0;
      else if (m_busy) begin if (m_bcnt == 1) m_busy = 0; else m_bcnt--; end
      if (start && known) begin
        m_busy = 1; m_run = req_wdata[13:8];
        m_bcnt = (req_wdata[13:8] == 6'h26) ? VERC : ADDC;
      end
      if (wctrl) begin m_en = req_wdata[0]; m_mode = req_wdata[13:8]; m_ie = req_wdata[31:0] & MASK; end
      m_flags = nf;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (irq !== |(m_flags & m_ie)) begin
        errors++; $display("FAIL R10 irq: got %b expected %b", irq, |(m_flags & m_ie));
      end
      checks++;
      if (rsp_valid !== m_rv || (m_rv && rsp_rdata !== m_rd)) begin
        errors++; $display("FAIL %s read: got %b/%h expected %b/%h", tag, rsp_valid, rsp_rdata, m_rv, m_rd);
      end
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [12:0] a, input logic [63:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic rd_expect(input logic [12:0] a, input logic [63:0] exp, input string t);
    @(negedge clk); tag = t; req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    checks++;
    if (rsp_rdata !== exp) begin
      errors++; $display("FAIL %s @%h: got %h expected %h", t, a, rsp_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd_expect(13'h000, 0, "R1"); rd_expect(13'h004, 0, "R1"); rd_expect(13'h5D0, 0, "R1");
    // R2 constants, writes ignored
    rd_expect(13'h1FF4, 64'h23, "R2"); rd_expect(13'h1FF8, 64'h0031_0017, "R2");
    tag = "R2"; wr(13'h1FF4, 64'hFF); rd_expect(13'h1FF4, 64'h23, "R2");
    // R12 window edges
    tag = "R12"; wr(13'h400, 64'hA5A5_0123_4567_89AB); wr(13'h18D0, 64'hFEED_BEEF_0000_0042);
    rd_expect(13'h400, 64'hA5A5_0123_4567_89AB, "R12"); rd_expect(13'h18D0, 64'hFEED_BEEF_0000_0042, "R12");
    // R7 unmapped / misaligned / beyond window
    rd_expect(13'h18D8, 0, "R7"); rd_expect(13'h004, 64'h0010_0000, "R7");
    tag = "R7"; wr(13'h404, 64'h1); wr(13'h00C, 64'h1);
    rd_expect(13'h004, 64'h0010_0000, "R7");
    // R9 clear, clear register reads zero
    tag = "R9"; wr(13'h008, 64'h0010_0000);
    rd_expect(13'h004, 0, "R9"); rd_expect(13'h008, 0, "R9");
    // R4 start together with enable is refused
    tag = "R4"; wr(13'h000, 64'h2603); rd_expect(13'h004, 0, "R4");
    // R3 init-ready
    idle(INIT + 2); rd_expect(13'h004, 64'h1, "R3");
    // R6 unknown mode
    tag = "R6"; wr(13'h000, 64'h0503); rd_expect(13'h004, 64'h0020_0001, "R6");
    // R10 interrupt enable at bit 21
    tag = "R10"; wr(13'h000, 64'h0020_0001); idle(2);
    wr(13'h008, 64'h0020_0000); idle(2);
    // R4/R5/R8 verification run
    tag = "R4"; wr(13'h000, 64'h0002_2603); rd_expect(13'h000, 64'h0002_2601, "R4");
    rd_expect(13'h004, 64'h0001_0001, "R4");
    tag = "R8"; wr(13'h400, 64'h1111); rd_expect(13'h400, 0, "R8");
    tag = "R4"; wr(13'h000, 64'h0002_0503); // ignored while busy
    idle(VERC + 4);
    rd_expect(13'h5D0, 64'hD60D, "R5"); rd_expect(13'h400, 64'hA5A5_0123_4567_89AB, "R8");
    rd_expect(13'h004, 64'h000A_0001, "R5");
    tag = "R9"; wr(13'h008, 64'h003A_0000);
    // addition run leaves memory
    tag = "R5"; wr(13'h000, 64'h0002_0903); idle(ADDC + 3);
    rd_expect(13'h400, 64'hA5A5_0123_4567_89AB, "R5"); rd_expect(13'h004, 64'h0002_0001, "R5");
    tag = "R9"; wr(13'h008, 64'h0002_0000);
    // R11 abort mid-run
    tag = "R11"; wr(13'h000, 64'h0002_2603); idle(5); wr(13'h000, 64'h0);
    rd_expect(13'h004, 0, "R11"); idle(VERC);
    rd_expect(13'h004, 0, "R11"); rd_expect(13'h5D0, 0, "R11");
    rd_expect(13'h400, 0, "R11"); rd_expect(13'h18D0, 0, "R11");
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule